// File: doc/BRIEF.md
# Byte-per-command I2C master

This block is an I2C bus master that transfers exactly one byte for each command. Software loads a byte into the data register. It then writes the control register with the go bit set and the per-byte flags. Those flags choose whether the bus sees a START before the byte, whether it sees a STOP after it, the direction of the byte and how the acknowledge bit is handled. The controller drives SCL and SDA as open-drain lines: it only pulls them low or lets them go. It runs the framing and the nine bit slots, then clears the busy bit and can raise a one-cycle interrupt.

A typical write frame is an address byte with START, then data bytes, with STOP on the last one. A read frame follows the address byte with read commands. Each read command carries the acknowledge value the master should send, with a NACK on the last byte. A pause command moves no data. It only frames the bus, usually to put out a STOP after the far end refused a byte.

The register port has no back-pressure. A write that arrives while busy is dropped. Software polls the busy bit or waits for the interrupt. All bus timing comes from the parameter `DIV`, which sets the length of one quarter of an SCL bit in clock cycles.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both registers read 0x00, neither line is pulled low and `irq` is low.
- R2: A command with go and start set produces one START condition and then shifts the data register out most-significant bit first. A receiving device sees exactly that byte.
- R3: On a write command, control bit 4 afterwards reads 1 if the device pulled SDA low in the ninth slot (ACK) and 0 if it left SDA high (NACK).
- R4: On a read command (control bit 5 = 1), the master releases SDA for eight slots and the data register afterwards holds the received byte. In the ninth slot the master pulls SDA low when control bit 4 was written 1, and leaves it high when bit 4 was 0.
- R5: Control bit 7 reads 1 from the cycle after a go write until the command ends, then 0. Writes to either register while it reads 1 are ignored.
- R6: `irq` is high for one cycle when busy falls, and only if control bit 6 was set for that command.
- R7: Control bit 1 = 0 means no START is generated. Control bit 0 = 0 means no STOP is generated, and the command leaves SCL held low.
- R8: With control bit 2 set, no data slots are clocked. Together with bit 0, the command produces a single SCL rise and one STOP.
- R9: SCL stays released for exactly 2*DIV clock cycles in every slot and stays low for at least 2*DIV cycles between slots. SDA never changes while SCL is released inside a data or acknowledge slot.
- R10: A control write with bit 7 = 0 stores the flags (readable back, bit 3 always reads 0) and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select for read and write: 0 data, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | One-cycle completion pulse |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The main function is exercised in four ways:
- A write whose address matches the modelled device: checks that the byte is shifted in the right order and that ACK is captured.
- A write to an address that does not match: the resulting NACK separates the two acknowledge outcomes.
- A read of two bytes from the modelled device, first with ACK and then with NACK plus STOP: checks both the captured data and the acknowledge level the master drives.
- A pause-plus-STOP command and a flag write without go: together these separate framing-only commands from data commands.

START and STOP conditions and SCL edges are counted on the bus. This confirms that each flag adds or removes exactly its own condition.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int BYTE_W = 8;
  localparam int CF_STOP  = 0;
  localparam int CF_START = 1;
  localparam int CF_PAUSE = 2;
  localparam int CF_ACK   = 4;
  localparam int CF_DIR   = 5;
  localparam int CF_IE    = 6;
  localparam int CF_BUSY  = 7;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_BIT   = 2'd2
  } line_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_BITS, SQ_ACK, SQ_STOP, SQ_DONE
  } seq_e;
endpackage

// File: rtl/i2cb_quarter_tick.sv
module i2cb_quarter_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cb_line_engine.sv
module i2cb_line_engine
  import i2cb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  line_op_e op,
  input  logic     tx_bit,
  input  logic     tick,
  input  logic     sda_in,
  output logic     busy,
  output logic     done,
  output logic     rx_bit,
  output logic     scl_low,
  output logic     sda_low
);
  line_op_e op_q;
  logic     bit_q;
  logic [1:0] phase;
  logic     nscl, nsda;

  always_comb begin
    case (op_q)
      OP_START: begin
        nscl = (phase == 2'd0) || (phase == 2'd3);
        nsda = phase[1];
      end
      OP_STOP: begin
        nscl = (phase == 2'd0);
        nsda = !phase[1];
      end
      default: begin
        nscl = (phase == 2'd0) || (phase == 2'd3);
        nsda = !bit_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      phase   <= 2'd0;
      op_q    <= OP_STOP;
      bit_q   <= 1'b1;
      rx_bit  <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          phase <= 2'd0;
          op_q  <= op;
          bit_q <= tx_bit;
        end
      end else begin
        scl_low <= nscl;
        sda_low <= nsda;
        if (tick) begin
          if (phase == 2'd1 && op_q == OP_BIT) rx_bit <= sda_in;
          if (phase == 2'd3) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          phase <= phase + 2'd1;
        end
      end
    end
  end

  // R9
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_BIT && !scl_low && !$past(scl_low)) |-> $stable(sda_low));

  // R2
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic              scl_low,
  input  logic              sda_in,
  output logic              sda_low
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  logic [BYTE_W-1:0] data_q, shreg;
  logic stop_q, start_q, pause_q, ack_q, dir_q, ie_q, busy_q;
  seq_e st;
  logic pend;
  logic [BCW-1:0] bitcnt;
  logic eng_go, eng_bit, eng_busy, eng_done, eng_rx, tick;
  line_op_e eng_op;
  logic launch;

  assign launch = bus_we && bus_sel && bus_wdata[CF_BUSY] && !busy_q;

  i2cb_quarter_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .tick(tick)
  );

  i2cb_line_engine u_eng (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .op(eng_op), .tx_bit(eng_bit),
    .tick(tick), .sda_in(sda_in), .busy(eng_busy), .done(eng_done),
    .rx_bit(eng_rx), .scl_low(scl_low), .sda_low(sda_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      shreg   <= '0;
      stop_q  <= 1'b0;
      start_q <= 1'b0;
      pause_q <= 1'b0;
      ack_q   <= 1'b0;
      dir_q   <= 1'b0;
      ie_q    <= 1'b0;
      busy_q  <= 1'b0;
      st      <= SQ_IDLE;
      pend    <= 1'b0;
      bitcnt  <= '0;
      eng_go  <= 1'b0;
      eng_op  <= OP_STOP;
      eng_bit <= 1'b1;
      irq     <= 1'b0;
    end else begin
      eng_go <= 1'b0;
      irq    <= 1'b0;
      if (st == SQ_IDLE) begin
        if (bus_we && !bus_sel) data_q <= bus_wdata;
        if (bus_we && bus_sel) begin
          stop_q  <= bus_wdata[CF_STOP];
          start_q <= bus_wdata[CF_START];
          pause_q <= bus_wdata[CF_PAUSE];
          ack_q   <= bus_wdata[CF_ACK];
          dir_q   <= bus_wdata[CF_DIR];
          ie_q    <= bus_wdata[CF_IE];
        end
        if (launch) begin
          busy_q <= 1'b1;
          pend   <= 1'b0;
          bitcnt <= '0;
          shreg  <= data_q;
          if (bus_wdata[CF_START])      st <= SQ_START;
          else if (!bus_wdata[CF_PAUSE]) st <= SQ_BITS;
          else if (bus_wdata[CF_STOP])   st <= SQ_STOP;
          else                           st <= SQ_DONE;
        end
      end else if (st == SQ_DONE) begin
        busy_q <= 1'b0;
        irq    <= ie_q;
        st     <= SQ_IDLE;
      end else if (!pend) begin
        pend   <= 1'b1;
        eng_go <= 1'b1;
        case (st)
          SQ_START: begin eng_op <= OP_START; eng_bit <= 1'b1; end
          SQ_STOP:  begin eng_op <= OP_STOP;  eng_bit <= 1'b1; end
          SQ_BITS:  begin eng_op <= OP_BIT;   eng_bit <= dir_q ? 1'b1 : shreg[BYTE_W-1]; end
          default:  begin eng_op <= OP_BIT;   eng_bit <= dir_q ? !ack_q : 1'b1; end
        endcase
      end else if (eng_done) begin
        pend <= 1'b0;
        case (st)
          SQ_START: st <= pause_q ? (stop_q ? SQ_STOP : SQ_DONE) : SQ_BITS;
          SQ_BITS: begin
            shreg  <= {shreg[BYTE_W-2:0], eng_rx};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) st <= SQ_ACK;
          end
          SQ_ACK: begin
            if (dir_q) data_q <= shreg;
            else       ack_q  <= !eng_rx;
            st <= stop_q ? SQ_STOP : SQ_DONE;
          end
          default: st <= SQ_DONE;
        endcase
      end
    end
  end

  assign bus_rdata = bus_sel
    ? {busy_q, ie_q, dir_q, ack_q, 1'b0, pause_q, start_q, stop_q}
    : data_q;

  // R6
  irq_on_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy_q && $past(busy_q) && ie_q));

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(bus_we && bus_sel && bus_wdata[CF_BUSY]));

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(dir_q) && $stable(ie_q) && $stable(stop_q)));

  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q)) |-> ($stable(scl_low) && $stable(sda_low)));
endmodule

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
  localparam int DIV = 8;
  localparam longint HI_NS = 2 * DIV * 10;
  localparam logic [6:0] SLV_ADDR = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic irq, scl_low_m, sda_low_m;
  logic sda_s = 1'b0;
  wire  scl = !scl_low_m;
  wire  sda = !(sda_low_m | sda_s);

  int checks = 0, errors = 0;

  i2c_byte_master #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_low(scl_low_m), .sda_in(sda), .sda_low(sda_low_m)
  );

  always #5 clk = !clk;

  // bus model of one device
  logic mon_en = 1'b0;
  logic active = 1'b0, is_addr = 1'b0, dir = 1'b0, matched = 1'b0;
  int bitcnt = 0, start_cnt = 0, stop_cnt = 0, rise_cnt = 0, irq_cnt = 0;
  logic [7:0] rx = 8'h00, last_rx = 8'h00, tx_base = 8'h00, tx_idx = 8'h00;
  logic mack = 1'b1;
  longint t_rise = 0, t_fall = 0, hi_min = 1000000, hi_max = 0, lo_min = 1000000;

  always @(negedge sda) if (mon_en && scl === 1'b1) begin
    start_cnt++; active = 1'b1; is_addr = 1'b1; bitcnt = 0; sda_s = 1'b0;
  end
  always @(posedge sda) if (mon_en && scl === 1'b1) begin
    stop_cnt++; active = 1'b0; sda_s = 1'b0;
  end

  always @(posedge scl) if (mon_en) begin
    rise_cnt++;
    t_rise = $time;
    if (active && (($time - t_fall) < lo_min)) lo_min = $time - t_fall;
    if (active) begin
      if (bitcnt < 8) begin
        rx = {rx[6:0], sda};
        bitcnt++;
        if (bitcnt == 8) begin
          last_rx = rx;
          if (is_addr) begin matched = (rx[7:1] == SLV_ADDR); dir = rx[0] && matched; end
        end
      end else if (bitcnt == 8) begin
        if (is_addr) is_addr = 1'b0;
        else if (dir) begin
          mack = sda; tx_idx = tx_idx + 8'd1;
          if (sda) dir = 1'b0;
        end
        bitcnt = 9;
      end
    end
  end

  always @(negedge scl) if (mon_en) begin
    t_fall = $time;
    if (active) begin
      if (($time - t_rise) < hi_min) hi_min = $time - t_rise;
      if (($time - t_rise) > hi_max) hi_max = $time - t_rise;
      if (bitcnt == 9) begin bitcnt = 0; sda_s = 1'b0; end
      if (bitcnt < 8) begin
        logic [7:0] tb;
        tb = tx_base + tx_idx;
        sda_s = (!is_addr && dir) ? !tb[7 - bitcnt] : 1'b0;
      end else if (bitcnt == 8) begin
        sda_s = (is_addr || !dir) ? matched : 1'b0;
      end
    end
  end

  always @(negedge clk) if (mon_en && irq) irq_cnt++;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk); bus_we = 1'b1; bus_sel = sel; bus_wdata = v;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk); bus_sel = sel; #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(1'b1, v);
      if (!v[7]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, v); check("R1 control after reset", v, 8'h00);
    rd(1'b0, v); check("R1 data after reset", v, 8'h00);
    check("R1 lines released", {scl_low_m, sda_low_m}, 2'b00);
    check("R1 irq low", irq, 1'b0);
  endtask

  task automatic t_addr_write();
    logic [7:0] v;
    wr(1'b0, 8'hA4);
    wr(1'b1, 8'hC2);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R2 device got address byte", last_rx, 8'hA4);
    check("R2 one START", start_cnt, 1);
    check("R7 no STOP without flag", stop_cnt, 0);
    check("R7 SCL held low after frame", scl_low_m, 1'b1);
    rd(1'b1, v);
    check("R3 ACK flag after ack", v[4], 1'b1);
    check("R5 busy cleared", v[7], 1'b0);
    check("R6 irq pulsed once", irq_cnt, 1);
  endtask

  task automatic t_data_write();
    logic [7:0] v;
    wr(1'b0, 8'h3C);
    wr(1'b1, 8'h81);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R2 device got data byte", last_rx, 8'h3C);
    check("R7 no START without flag", start_cnt, 1);
    check("R2 STOP issued", stop_cnt, 1);
    check("R6 no irq without enable", irq_cnt, 1);
    rd(1'b1, v);
    check("R3 ACK flag on data", v[4], 1'b1);
  endtask

  task automatic t_nack();
    logic [7:0] v;
    wr(1'b0, 8'h90);
    wr(1'b1, 8'h83);
    wait_idle();
    rd(1'b1, v);
    check("R3 ACK flag after NACK", v[4], 1'b0);
    check("R2 START count", start_cnt, 2);
  endtask

  task automatic t_read();
    logic [7:0] v;
    tx_base = 8'h5A; tx_idx = 8'h00;
    wr(1'b0, 8'hA5);
    wr(1'b1, 8'h82);
    wait_idle();
    wr(1'b1, 8'hB0);
    wait_idle();
    rd(1'b0, v);
    check("R4 first read byte", v, 8'h5A);
    check("R4 master ACK driven low", mack, 1'b0);
    wr(1'b1, 8'hA1);
    wait_idle();
    rd(1'b0, v);
    check("R4 second read byte", v, 8'h5B);
    check("R4 master NACK left high", mack, 1'b1);
    check("R4 STOP after last read", stop_cnt, 3);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'hC3);
    rd(1'b1, v);
    check("R5 busy reads 1 mid-transfer", v[7], 1'b1);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h00);
    wait_idle();
    rd(1'b0, v);
    check("R5 data write ignored while busy", v, 8'h11);
    rd(1'b1, v);
    check("R5 control write ignored while busy", v, 8'h43);
  endtask

  task automatic t_pause();
    int r0;
    wr(1'b0, 8'hA4);
    wr(1'b1, 8'h82);
    wait_idle();
    r0 = rise_cnt;
    wr(1'b1, 8'h85);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R8 single SCL rise on pause", rise_cnt - r0, 1);
    check("R8 STOP from pause", stop_cnt, 5);
    check("R8 lines released", {scl_low_m, sda_low_m}, 2'b00);
  endtask

  task automatic t_flags_only();
    logic [7:0] v;
    int r0;
    r0 = rise_cnt;
    wr(1'b1, 8'h5F);
    repeat (4 * DIV * 3) @(negedge clk);
    rd(1'b1, v);
    check("R10 flags stored, bit3 zero", v, 8'h57);
    check("R10 no SCL activity", rise_cnt - r0, 0);
    check("R10 lines released", {scl_low_m, sda_low_m}, 2'b00);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    t_reset();
    t_addr_write();
    t_data_write();
    t_nack();
    t_read();
    t_busy_ignore();
    t_pause();
    t_flags_only();
    check("R9 SCL high time min", hi_min, HI_NS);
    check("R9 SCL high time max", hi_max, HI_NS);
    check("R9 SCL low time at least 2*DIV", (lo_min >= HI_NS), 1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule